// File: doc/BRIEF.md
# UART Interrupt Status and Routing

This block is the interrupt section of a memory-mapped serial port. Pulses from the receive path, the transmit path, the receive timeout timer, the four modem-status detectors and the four error detectors each set one bit of a raw status register. That register is ANDed with a software-written mask. The result drives six registered interrupt lines: one combined line and five lines, one per event group.

Software uses a word-addressed register port inside a 4 KB window (10-bit word offset). The port gives access to the mask, a read-only raw view and a read-only masked view. It also has a write-one-to-clear register and plain storage for line control, the two baud divisors, an infrared low-power divisor and a DMA control word. The top eight words of the window return fixed identification bytes. A parameter picks one of two identification sets. Reads are combinational from the word offset; writes take effect at the clock edge on which `wr_en` is high.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the mask (word 0x010), raw status (0x011), integer divisor (0x003), fractional divisor (0x004), infrared divisor (0x005) and DMA control (0x006) all read 0, and all six interrupt outputs are low.
- R2: A one-cycle event pulse sets its raw bit. The bit positions are: ring 0, clear-to-send 1, carrier 2, data-set-ready 3 (from `evt_ms[3:0]`), receive 4, transmit 5, timeout 6, and errors 7 to 10 (from `evt_err[3:0]`). Raw bits never rise without a cause.
- R3: Word 0x012 reads raw status ANDed with the mask. The mask does not alter the raw view.
- R4: A write to word 0x013 clears every raw bit whose written bit is one and leaves the other bits unchanged. Reading word 0x013 returns 0.
- R5: `irq_rx`, `irq_tx` and `irq_rt` follow masked bits 4, 5 and 6. `irq_ms` is the OR of masked bits 0 to 3. `irq_err` is the OR of masked bits 7 to 10. `irq_comb` is the OR of all eleven masked bits.
- R6: Any write to the data word (0x000) sets raw bit 5, whatever value is written.
- R7: Writes to the raw (0x011), masked (0x012) and flag (0x001) words have no effect. The flag word always reads 0.
- R8: Word offsets 0x3F8 to 0x3FF return the bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order with `ID_SET`=0. With `ID_SET`=1 they return 0x11, 0x00, 0x18, 0x01, 0x0D, 0xF0, 0x05, 0xB1. Unmapped words read 0.
- R9: The integer divisor keeps bits 15:0 of the written value and the fractional divisor keeps bits 5:0. Line control (0x002) and the infrared divisor keep 8 bits, and DMA control keeps 3 bits.
- R10: The interrupt outputs are registered. They change on the clock edge that captures the causing event or register write, including a mask write. They do not change before that edge.
- R11: When an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 10 | Word offset within the 4 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| evt_rx | input | 1 | Receive event pulse |
| evt_tx | input | 1 | Transmit event pulse |
| evt_rt | input | 1 | Receive timeout event pulse |
| evt_ms | input | 4 | Modem-status event pulses (ring, CTS, carrier, DSR) |
| evt_err | input | 4 | Error event pulses (framing, parity, break, overrun) |
| irq_comb | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rt | output | 1 | Receive timeout interrupt |
| irq_ms | output | 1 | Modem-status interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The assertions assume that event inputs and write strobes are known (not X) whenever reset is released. They also assume that `addr` is stable while a read is being observed. The stimulus drives every input only at the falling clock edge and returns event pulses to zero after exactly one cycle. This keeps each raw-bit rise traceable to a single captured pulse or data write. The set-versus-clear collision is created on purpose in a single cycle. Every other clear is issued with no event active, so each check of clearing behaviour sees only the write-one-to-clear path.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC  = 11;
    localparam int NUM_IRQ  = 6;
    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 32;
    localparam int IDIV_W   = 16;
    localparam int FDIV_W   = 6;
    localparam int LINE_W   = 8;
    localparam int IRDA_W   = 8;
    localparam int DMA_W    = 3;
    localparam int CFG_IN_W = 16;

    // raw status bit positions
    localparam int B_RI  = 0;
    localparam int B_CTS = 1;
    localparam int B_DCD = 2;
    localparam int B_DSR = 3;
    localparam int B_RX  = 4;
    localparam int B_TX  = 5;
    localparam int B_RT  = 6;
    localparam int B_ERR_LO = 7;
    localparam int B_ERR_HI = 10;

    // word offsets
    localparam logic [ADDR_W-1:0] A_DATA   = 10'h000;
    localparam logic [ADDR_W-1:0] A_FLAG   = 10'h001;
    localparam logic [ADDR_W-1:0] A_LINE   = 10'h002;
    localparam logic [ADDR_W-1:0] A_IDIV   = 10'h003;
    localparam logic [ADDR_W-1:0] A_FDIV   = 10'h004;
    localparam logic [ADDR_W-1:0] A_IRDA   = 10'h005;
    localparam logic [ADDR_W-1:0] A_DMA    = 10'h006;
    localparam logic [ADDR_W-1:0] A_MASK   = 10'h010;
    localparam logic [ADDR_W-1:0] A_RAW    = 10'h011;
    localparam logic [ADDR_W-1:0] A_MSKD   = 10'h012;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 10'h013;
    localparam logic [ADDR_W-4:0] A_ID_HI  = 7'h7F;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t            raw;
        src_vec_t            mask;
        logic [NUM_IRQ-1:0]  irq;
    } irq_state_t;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [IDIV_W-1:0] idiv;
        logic [FDIV_W-1:0] fdiv;
        logic [IRDA_W-1:0] irda;
        logic [DMA_W-1:0]  dma;
    } cfg_state_t;

    // Which raw bits feed each interrupt line: 0 combined, 1 rx, 2 tx,
    // 3 timeout, 4 modem status, 5 error.
    function automatic src_vec_t irq_sel(input int k);
        src_vec_t s;
        s = '0;
        case (k)
            0: s = '1;
            1: s[B_RX] = 1'b1;
            2: s[B_TX] = 1'b1;
            3: s[B_RT] = 1'b1;
            4: s[B_DSR:B_RI] = '1;
            5: s[B_ERR_HI:B_ERR_LO] = '1;
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
#(
    parameter int ID_SET = 0
) (
    input  logic [2:0] idx,
    output logic [7:0] id_byte
);

    generate
        if (ID_SET == 0) begin : g_set_a
            always_comb begin
                case (idx)
                    3'd0: id_byte = 8'h11;
                    3'd1: id_byte = 8'h10;
                    3'd2: id_byte = 8'h14;
                    3'd3: id_byte = 8'h00;
                    3'd4: id_byte = 8'h0D;
                    3'd5: id_byte = 8'hF0;
                    3'd6: id_byte = 8'h05;
                    default: id_byte = 8'hB1;
                endcase
            end
        end else begin : g_set_b
            always_comb begin
                case (idx)
                    3'd0: id_byte = 8'h11;
                    3'd1: id_byte = 8'h00;
                    3'd2: id_byte = 8'h18;
                    3'd3: id_byte = 8'h01;
                    3'd4: id_byte = 8'h0D;
                    3'd5: id_byte = 8'hF0;
                    3'd6: id_byte = 8'h05;
                    default: id_byte = 8'hB1;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/uart_irq_cfg.sv
module uart_irq_cfg
    import uart_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [CFG_IN_W-1:0] wdata,
    output logic [LINE_W-1:0]   line_o,
    output logic [IDIV_W-1:0]   idiv_o,
    output logic [FDIV_W-1:0]   fdiv_o,
    output logic [IRDA_W-1:0]   irda_o,
    output logic [DMA_W-1:0]    dma_o
);

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (addr)
                A_LINE: cfg_d.line = wdata[LINE_W-1:0];
                A_IDIV: cfg_d.idiv = wdata[IDIV_W-1:0];
                A_FDIV: cfg_d.fdiv = wdata[FDIV_W-1:0];
                A_IRDA: cfg_d.irda = wdata[IRDA_W-1:0];
                A_DMA:  cfg_d.dma  = wdata[DMA_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign line_o = cfg_q.line;
    assign idiv_o = cfg_q.idiv;
    assign fdiv_o = cfg_q.fdiv;
    assign irda_o = cfg_q.irda;
    assign dma_o  = cfg_q.dma;

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == A_IDIV || addr == A_FDIV)) |=> $stable({cfg_q.idiv, cfg_q.fdiv})); // R9

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_SRC-1:0]  wdata,
    input  src_vec_t            evt_set,
    output src_vec_t            raw_o,
    output src_vec_t            mask_o,
    output logic [NUM_IRQ-1:0]  irq_o
);

    irq_state_t st_d, st_q;
    src_vec_t   set_vec;
    src_vec_t   clr_vec;
    src_vec_t   masked_d;

    always_comb begin
        st_d    = st_q;
        set_vec = evt_set;
        clr_vec = '0;
        if (wr_en && addr == A_DATA)  set_vec[B_TX] = 1'b1;
        if (wr_en && addr == A_CLEAR) clr_vec = wdata;
        if (wr_en && addr == A_MASK)  st_d.mask = wdata;
        // a new event wins over a clear of the same bit
        st_d.raw = (st_q.raw & ~clr_vec) | set_vec;
        masked_d = st_d.raw & st_d.mask;
        for (int k = 0; k < NUM_IRQ; k++) begin
            st_d.irq[k] = |(masked_d & irq_sel(k));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o  = st_q.raw;
    assign mask_o = st_q.mask;
    assign irq_o  = st_q.irq;

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.raw & ~$past(st_q.raw) & ~$past(set_vec)) == '0)); // R2
    AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((st_q.raw & $past(clr_vec & ~set_vec)) == '0)); // R4
    AST_TX_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DATA) |=> st_q.raw[B_TX]); // R6
    AST_COMB_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq[0] == |st_q.irq[NUM_IRQ-1:1]); // R5
    AST_MASK_REEVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MASK) |=> (st_q.irq[0] == |(st_q.raw & st_q.mask))); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set[B_RX] && clr_vec[B_RX]) |=> st_q.raw[B_RX]); // R11

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int ID_SET = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [9:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        evt_rx,
    input  logic        evt_tx,
    input  logic        evt_rt,
    input  logic [3:0]  evt_ms,
    input  logic [3:0]  evt_err,
    output logic        irq_comb,
    output logic        irq_rx,
    output logic        irq_tx,
    output logic        irq_rt,
    output logic        irq_ms,
    output logic        irq_err
);

    src_vec_t           evt_set;
    src_vec_t           raw_w, mask_w;
    logic [NUM_IRQ-1:0] irq_w;
    logic [LINE_W-1:0]  line_w;
    logic [IDIV_W-1:0]  idiv_w;
    logic [FDIV_W-1:0]  fdiv_w;
    logic [IRDA_W-1:0]  irda_w;
    logic [DMA_W-1:0]   dma_w;
    logic [7:0]         id_w;
    logic               unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:CFG_IN_W];

    always_comb begin
        evt_set = '0;
        evt_set[B_DSR:B_RI]         = evt_ms;
        evt_set[B_RX]               = evt_rx;
        evt_set[B_TX]               = evt_tx;
        evt_set[B_RT]               = evt_rt;
        evt_set[B_ERR_HI:B_ERR_LO]  = evt_err;
    end

    uart_irq_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata[NUM_SRC-1:0]),
        .evt_set (evt_set),
        .raw_o   (raw_w),
        .mask_o  (mask_w),
        .irq_o   (irq_w)
    );

    uart_irq_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata[CFG_IN_W-1:0]),
        .line_o (line_w),
        .idiv_o (idiv_w),
        .fdiv_o (fdiv_w),
        .irda_o (irda_w),
        .dma_o  (dma_w)
    );

    uart_irq_id #(.ID_SET(ID_SET)) u_id (
        .idx     (addr[2:0]),
        .id_byte (id_w)
    );

    always_comb begin
        rdata = '0;
        if (addr[ADDR_W-1:3] == A_ID_HI) begin
            rdata[7:0] = id_w;
        end else begin
            case (addr)
                A_LINE:  rdata[LINE_W-1:0]  = line_w;
                A_IDIV:  rdata[IDIV_W-1:0]  = idiv_w;
                A_FDIV:  rdata[FDIV_W-1:0]  = fdiv_w;
                A_IRDA:  rdata[IRDA_W-1:0]  = irda_w;
                A_DMA:   rdata[DMA_W-1:0]   = dma_w;
                A_MASK:  rdata[NUM_SRC-1:0] = mask_w;
                A_RAW:   rdata[NUM_SRC-1:0] = raw_w;
                A_MSKD:  rdata[NUM_SRC-1:0] = raw_w & mask_w;
                default: rdata = '0;
            endcase
        end
    end

    assign irq_comb = irq_w[0];
    assign irq_rx   = irq_w[1];
    assign irq_tx   = irq_w[2];
    assign irq_rt   = irq_w[3];
    assign irq_ms   = irq_w[4];
    assign irq_err  = irq_w[5];

    AST_ID_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 10'h3F8) |-> (rdata == 32'h11)); // R8
    AST_RX_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx == (raw_w[B_RX] & mask_w[B_RX])); // R5

endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
`timescale 1ns/10ps
module uart_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        evt_rx = 0, evt_tx = 0, evt_rt = 0;
    logic [3:0]  evt_ms = '0, evt_err = '0;
    logic        irq_comb, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     sample_ev;

    always #2 clk = ~clk;

    uart_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .evt_rx(evt_rx), .evt_tx(evt_tx), .evt_rt(evt_rt),
        .evt_ms(evt_ms), .evt_err(evt_err), .irq_comb(irq_comb), .irq_rx(irq_rx),
        .irq_tx(irq_tx), .irq_rt(irq_rt), .irq_ms(irq_ms), .irq_err(irq_err)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [31:0] obs;
                it = sb_q.pop_front();
                obs = it.is_irq ? {26'd0, irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_comb}
                                : rdata;
                checks++;
                if (obs !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, obs, it.exp);
                end
            end
        end
    end

    task automatic push_exp(input bit is_irq, input logic [31:0] exp, input string tag);
        sb_item_t it;
        it.is_irq = is_irq; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        ->sample_ev;
        #0.5;
    endtask

    // irq vector bits: {err, ms, rt, tx, rx, comb}
    task automatic exp_irq(input logic [5:0] v, input string tag);
        push_exp(1'b1, {26'd0, v}, tag);
        @(negedge clk);
    endtask

    task automatic exp_rd(input logic [9:0] a, input logic [31:0] v, input string tag);
        addr = a;
        #0.5;
        push_exp(1'b0, v, tag);
        @(negedge clk);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] v);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic rx, input logic tx, input logic rt,
                         input logic [3:0] ms, input logic [3:0] er);
        evt_rx = rx; evt_tx = tx; evt_rt = rt; evt_ms = ms; evt_err = er;
        @(negedge clk);
        evt_rx = 0; evt_tx = 0; evt_rt = 0; evt_ms = '0; evt_err = '0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] ids [8];
        ids = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        exp_rd(10'h010, 32'h0, "R1 mask");
        exp_rd(10'h011, 32'h0, "R1 raw");
        exp_rd(10'h003, 32'h0, "R1 idiv");
        exp_rd(10'h004, 32'h0, "R1 fdiv");
        exp_rd(10'h005, 32'h0, "R1 irda");
        exp_rd(10'h006, 32'h0, "R1 dma");
        exp_irq(6'b000000, "R1 irqs low");

        // R10 and R2: receive event, output only after the edge
        wr(10'h010, 32'h7FF);
        evt_rx = 1'b1;
        #0.5;
        push_exp(1'b1, 32'h0, "R10 no change before edge");
        @(negedge clk);
        evt_rx = 1'b0;
        push_exp(1'b1, 32'h03, "R10 rx after edge");
        exp_rd(10'h011, 32'h010, "R2 rx raw bit 4");
        exp_irq(6'b000011, "R5 rx line");

        // R4 clear
        wr(10'h013, 32'h010);
        exp_rd(10'h011, 32'h0, "R4 rx cleared");
        exp_irq(6'b000000, "R4 irqs drop");
        exp_rd(10'h013, 32'h0, "R4 clear reads zero");

        // R2 and R5 other groups
        pulse(0, 0, 0, 4'b0100, 4'b0000);
        exp_rd(10'h011, 32'h004, "R2 carrier bit 2");
        exp_irq(6'b010001, "R5 modem line");
        pulse(0, 0, 0, 4'b0000, 4'b0010);
        exp_rd(10'h011, 32'h104, "R2 parity bit 8");
        exp_irq(6'b110001, "R5 err+modem");
        wr(10'h013, 32'h004);
        exp_rd(10'h011, 32'h100, "R4 partial clear");
        pulse(0, 0, 1, 4'b0000, 4'b0000);
        exp_irq(6'b101001, "R5 rt+err");
        wr(10'h013, 32'h7FF);
        exp_irq(6'b000000, "R4 clear all");

        // R3 masking and R10 mask re-evaluation
        wr(10'h010, 32'h010);
        pulse(0, 1, 0, 4'b0000, 4'b0000);
        exp_irq(6'b000000, "R3 tx masked off");
        exp_rd(10'h011, 32'h020, "R3 raw unaffected");
        exp_rd(10'h012, 32'h000, "R3 masked view zero");
        wr(10'h010, 32'h030);
        exp_irq(6'b000101, "R10 mask write reevaluates");
        exp_rd(10'h012, 32'h020, "R3 masked view tx");
        wr(10'h013, 32'h7FF);

        // R6 data write sets tx
        wr(10'h000, 32'h0);
        exp_rd(10'h011, 32'h020, "R6 data write tx");
        exp_irq(6'b000101, "R6 tx irq");
        wr(10'h013, 32'h020);

        // R7 ignored writes
        wr(10'h010, 32'h7FF);
        wr(10'h011, 32'h7FF);
        wr(10'h012, 32'h7FF);
        wr(10'h001, 32'hFFFF);
        exp_rd(10'h011, 32'h0, "R7 raw unchanged");
        exp_irq(6'b000000, "R7 no irq");
        exp_rd(10'h001, 32'h0, "R7 flag reads zero");

        // R8 identification bytes and unmapped words
        for (int i = 0; i < 8; i++) begin
            exp_rd(10'h3F8 + 10'(i), {24'd0, ids[i]}, "R8 id byte");
        end
        exp_rd(10'h3F7, 32'h0, "R8 unmapped below id");
        exp_rd(10'h200, 32'h0, "R8 unmapped mid");

        // R9 field widths
        wr(10'h003, 32'hFFFF_FFFF);
        wr(10'h004, 32'hFFFF_FFFF);
        wr(10'h002, 32'h000A_BCDE);
        wr(10'h005, 32'h0000_1234);
        wr(10'h006, 32'h0000_00FF);
        exp_rd(10'h003, 32'h0000_FFFF, "R9 idiv 16 bits");
        exp_rd(10'h004, 32'h0000_003F, "R9 fdiv 6 bits");
        exp_rd(10'h002, 32'h0000_00DE, "R9 line 8 bits");
        exp_rd(10'h005, 32'h0000_0034, "R9 irda 8 bits");
        exp_rd(10'h006, 32'h0000_0007, "R9 dma 3 bits");

        // R11 set wins over clear in the same cycle
        evt_rx = 1'b1; wr_en = 1'b1; addr = 10'h013; wdata = 32'h010;
        @(negedge clk);
        evt_rx = 1'b0; wr_en = 1'b0; wdata = '0;
        exp_rd(10'h011, 32'h010, "R11 set wins");
        exp_irq(6'b000011, "R11 rx irq kept");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule